// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation analog-to-digital converter. Software requests a conversion by setting a go bit. The block samples that bit on the last phase strobe of an instruction cycle. It then waits a fixed start delay and counts conversion clock ticks. On each tick it resolves one result bit from the comparator decision. The comparator, the trial DAC, the hold capacitor and the clock sources are outside the block. They connect through a sample-enable output, a trial-code output and a one-bit comparator input.

The system clock runs at twice the oscillator frequency, so one clock equals half an oscillator period. An instruction cycle lasts `TCY_CLKS` clocks. The start delay is half an oscillator period plus one instruction cycle. When the slow internal RC source is selected, one more instruction cycle is added so that the core can enter sleep first. The conversion uses 11 conversion clock ticks. The first tick loads the MSB trial. Each of the next ten ticks decides one bit, from the MSB down to the LSB. On the last tick, three things happen in the same clock: the result register is loaded, the interrupt flag is raised and the go bit drops.

Top module: `adc_sar_seq`

## Requirements
- R1: After synchronous reset, go_done, irq_flag, result and dac_code are all 0 and sample_en is 1.
- R2: With clk_sel not equal to 2'b11, sample_en falls exactly TCY_CLKS+1 clocks after the rising clock edge where go_done is 1 and q4_strobe is 1.
- R3: With clk_sel equal to 2'b11 (RC source), that delay becomes 2*TCY_CLKS+1 clocks.
- R4: sample_en is 0 only while the bit conversion runs, and dac_code is 0 whenever sample_en is 1.
- R5: The first ad_tick of a conversion sets dac_code to 10'h200. Each later tick stores cmp_hi (1 = input at or above trial) into the current bit and sets the next lower bit to 1. A conversion of a static input therefore yields that input's code.
- R6: On the 11th ad_tick, result takes the final code, irq_flag is set and go_done clears, all in the same clock. sample_en returns to 1 in that clock too.
- R7: go_set while a request is pending or converting has no effect on timing, bits or result.
- R8: go_clr during the delay or the conversion aborts it. go_done and dac_code return to 0 and sample_en returns to 1. result and irq_flag do not change.
- R9: irq_flag stays set until flag_clr. If flag_clr comes in the same clock as a completion, the flag stays set.
- R10: ad_tick pulses outside a conversion do not change dac_code or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, half an oscillator period |
| rst | input | 1 | Synchronous active-high reset |
| go_set | input | 1 | Software write of 1 to the go bit |
| go_clr | input | 1 | Software write of 0 to the go bit |
| q4_strobe | input | 1 | Last-phase strobe, once per instruction cycle |
| clk_sel | input | 2 | Conversion clock source, 2'b11 = internal RC |
| ad_tick | input | 1 | One-clock pulse per conversion clock period |
| cmp_hi | input | 1 | Comparator: 1 when input is at or above trial level |
| flag_clr | input | 1 | Software clear of the interrupt flag |
| sample_en | output | 1 | Hold-capacitor sampling enable |
| dac_code | output | 10 | Trial code driven to the DAC |
| result | output | 10 | Conversion result register |
| irq_flag | output | 1 | Conversion-complete interrupt flag |
| go_done | output | 1 | Go/done status bit |

## Verification
The flag must handle two events in the same clock: the completion that sets it and a software clear. The bench forces this overlap. It watches its own model's tick count and raises flag_clr in exactly the clock that carries the eleventh tick. The bench then expects the flag to remain set. A behavioural model computes the expected sample_en, dac_code, result, flag and go bit for every clock from the inputs alone. The bench compares these in every cycle, so this overlap is judged under the same comparison as the start delays for both clock sources, the mid-conversion go write and the abort.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W  = 10;
    localparam int IDX_W  = $clog2(RES_W);
    localparam logic [1:0] SEL_RC = 2'b11;

    typedef logic [RES_W-1:0] code_t;

    typedef struct packed {
        logic  busy;
        logic  done;
        code_t trial;
        code_t final_code;
    } sar_stat_t;

    function automatic logic sel_is_rc(input logic [1:0] sel);
        return sel == SEL_RC;
    endfunction

    function automatic int start_delay(input logic rc, input int tcy);
        return tcy + 1 + (rc ? tcy : 0);
    endfunction

    function automatic code_t trial_step(input code_t code,
                                         input logic [IDX_W-1:0] idx,
                                         input logic keep);
        code_t c;
        c = code;
        c[idx] = keep;
        if (idx != '0) c[idx - 1'b1] = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/adc_go_ctrl.sv
module adc_go_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic go_set,
    input  logic go_clr,
    input  logic flag_clr,
    input  logic q4_strobe,
    input  logic active,
    input  logic done,
    output logic go_q,
    output logic flag_q,
    output logic start,
    output logic abort
);
    assign abort = go_clr && active;
    assign start = go_q && q4_strobe && !active && !go_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (go_clr)                 go_q <= 1'b0;
            else if (done)              go_q <= 1'b0;
            else if (go_set && !active) go_q <= 1'b1;

            if (done)          flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_start_timer.sv
module adc_start_timer #(
    parameter int TCY_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] clk_sel,
    input  logic       abort,
    output logic       busy,
    output logic       fire
);
    import adc_seq_pkg::*;

    localparam int MAX_DLY = 2 * TCY_CLKS + 1;
    localparam int CW      = $clog2(MAX_DLY + 1);

    logic [CW-1:0] cnt;

    assign fire = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(start_delay(sel_is_rc(clk_sel), TCY_CLKS) - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   begin_conv,
    input  logic                   abort,
    input  logic                   tick,
    input  logic                   cmp_hi,
    output adc_seq_pkg::sar_stat_t stat
);
    import adc_seq_pkg::*;

    logic             busy;
    logic             primed;
    logic [IDX_W-1:0] idx;
    code_t            trial;
    code_t            next_code;

    assign next_code       = trial_step(trial, idx, cmp_hi);
    assign stat.busy       = busy;
    assign stat.trial      = trial;
    assign stat.final_code = next_code;
    assign stat.done       = busy && tick && primed && (idx == '0);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy   <= 1'b0;
            primed <= 1'b0;
            idx    <= '0;
            trial  <= '0;
        end else if (begin_conv) begin
            busy   <= 1'b1;
            primed <= 1'b0;
            idx    <= '0;
            trial  <= '0;
        end else if (busy && tick) begin
            if (!primed) begin
                primed <= 1'b1;
                idx    <= IDX_W'(RES_W - 1);
                trial  <= code_t'(1) << (RES_W - 1);
            end else if (idx == '0) begin
                busy   <= 1'b0;
                primed <= 1'b0;
                trial  <= '0;
            end else begin
                trial  <= next_code;
                idx    <= idx - 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
    parameter int TCY_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go_set,
    input  logic       go_clr,
    input  logic       q4_strobe,
    input  logic [1:0] clk_sel,
    input  logic       ad_tick,
    input  logic       cmp_hi,
    input  logic       flag_clr,
    output logic       sample_en,
    output logic [9:0] dac_code,
    output logic [9:0] result,
    output logic       irq_flag,
    output logic       go_done
);
    import adc_seq_pkg::*;

    logic      tmr_busy;
    logic      tmr_fire;
    logic      start;
    logic      abort;
    logic      active;
    sar_stat_t stat;
    code_t     result_q;

    assign active = tmr_busy || stat.busy;

    adc_go_ctrl u_go (
        .clk       (clk),
        .rst       (rst),
        .go_set    (go_set),
        .go_clr    (go_clr),
        .flag_clr  (flag_clr),
        .q4_strobe (q4_strobe),
        .active    (active),
        .done      (stat.done),
        .go_q      (go_done),
        .flag_q    (irq_flag),
        .start     (start),
        .abort     (abort)
    );

    adc_start_timer #(.TCY_CLKS(TCY_CLKS)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .clk_sel (clk_sel),
        .abort   (abort),
        .busy    (tmr_busy),
        .fire    (tmr_fire)
    );

    adc_sar_core u_core (
        .clk        (clk),
        .rst        (rst),
        .begin_conv (tmr_fire),
        .abort      (abort),
        .tick       (ad_tick),
        .cmp_hi     (cmp_hi),
        .stat       (stat)
    );

    always_ff @(posedge clk) begin
        if (rst)            result_q <= '0;
        else if (stat.done) result_q <= stat.final_code;
    end

    assign result    = result_q;
    assign dac_code  = stat.trial;
    assign sample_en = !stat.busy;
endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       go_clr,
    input logic       flag_clr,
    input logic       sample_en,
    input logic [9:0] dac_code,
    input logic [9:0] result,
    input logic       irq_flag,
    input logic       go_done
);
    // R4
    idle_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> dac_code == 10'd0);

    // R4
    conv_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |-> go_done);

    // R2
    conv_start_after_go_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sample_en) |-> $past(go_done));

    // R6
    result_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> irq_flag && !go_done && sample_en);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        irq_flag && !flag_clr |=> irq_flag);

    // R8
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        go_clr |=> !go_done && sample_en);
endmodule

bind adc_sar_seq adc_sar_seq_chk chk_i (.*);

// File: tb/adc_sar_seq_test.sv
module adc_sar_seq_test;
    localparam int TCY = 8;
    localparam int N   = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       go_set = 1'b0, go_clr = 1'b0, q4_strobe = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic       ad_tick = 1'b0, cmp_hi = 1'b0, flag_clr = 1'b0;
    logic       sample_en, irq_flag, go_done;
    logic [9:0] dac_code, result;

    adc_sar_seq #(.TCY_CLKS(TCY)) uut (.*);

    always #2 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    int tick_div = 3, tick_ph = 0, q4_ph = 0, vin = 0;
    bit ticks_on = 1'b1, clr_at_done = 1'b0, clr_req = 1'b0;

    // behavioural reference
    int m_phase = 0, m_dleft = 0, m_ticks = 0, m_pos = 0, m_trial = 0, m_result = 0;
    bit m_flag = 0, m_go = 0, m_done = 0, m_act = 0;
    int m_sel = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_phase = 0; m_trial = 0; m_result = 0; m_flag = 0; m_go = 0;
        end else begin
            m_done = 0;
            m_act  = (m_phase != 0);
            if (go_clr && m_act) begin
                m_phase = 0; m_trial = 0;
            end else if (m_phase == 0) begin
                if (m_go && q4_strobe && !go_clr) begin
                    m_phase = 1;
                    m_sel   = clk_sel;
                    m_dleft = TCY + 1 + ((clk_sel == 2'b11) ? TCY : 0);
                end
            end else if (m_phase == 1) begin
                m_dleft--;
                if (m_dleft == 0) begin m_phase = 2; m_ticks = 0; end
            end else if (ad_tick) begin
                if (m_ticks == 0) begin
                    m_trial = 1 << (N - 1); m_pos = N - 1;
                end else begin
                    if (!cmp_hi) m_trial = m_trial & ~(1 << m_pos);
                    if (m_pos == 0) begin
                        m_result = m_trial; m_done = 1; m_phase = 0; m_trial = 0;
                    end else begin
                        m_pos--; m_trial = m_trial | (1 << m_pos);
                    end
                end
                m_ticks++;
            end
            if (m_done) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (go_clr) m_go = 0;
            else if (m_done) m_go = 0;
            else if (go_set && !m_act) m_go = 1;
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R6 watchdog: cycles %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk((m_sel == 3) ? "R3 sample_en" : "R2 sample_en", int'(sample_en), int'(m_phase != 2));
            chk("R5 dac_code", int'(dac_code), m_trial);
            chk("R6 result", int'(result), m_result);
            chk("R9 irq_flag", int'(irq_flag), int'(m_flag));
            chk("R7 go_done", int'(go_done), int'(m_go));
        end
    end

    // stimulus generators
    always @(negedge clk) begin
        q4_ph     = (q4_ph + 1) % TCY;
        q4_strobe = (q4_ph == 0);
        tick_ph   = (tick_ph + 1) % tick_div;
        ad_tick   = ticks_on && (tick_ph == 0);
        cmp_hi    = (vin >= int'(dac_code));
        flag_clr  = clr_req || (clr_at_done && m_phase == 2 && m_ticks == N && ad_tick);
    end

    task automatic pulse_go(input bit set);
        @(negedge clk);
        if (set) go_set = 1'b1; else go_clr = 1'b1;
        @(negedge clk);
        go_set = 1'b0; go_clr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_go || m_phase != 0);
    endtask

    task automatic convert(input int v, input logic [1:0] sel, input int div);
        vin = v; clk_sel = sel; tick_div = div;
        pulse_go(1'b1);
        wait_idle();
        @(negedge clk);
        chk("R5 final code", int'(result), v);
        chk("R6 flag after completion", int'(irq_flag), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state (first cycle after release)
        @(negedge clk);
        chk("R1 go_done", int'(go_done), 0);
        chk("R1 irq_flag", int'(irq_flag), 0);
        chk("R1 result", int'(result), 0);
        chk("R1 dac_code", int'(dac_code), 0);
        chk("R1 sample_en", int'(sample_en), 1);

        convert(10'h2A5, 2'b00, 3);               // R2
        // R10 idle ticks change nothing
        tick_div = 1;
        repeat (30) @(negedge clk);
        chk("R10 dac idle", int'(dac_code), 0);
        chk("R10 result idle", int'(result), 10'h2A5);
        clear_flag();
        @(negedge clk);
        chk("R9 flag cleared", int'(irq_flag), 0);

        convert(10'h3FF, 2'b11, 4);               // R3
        convert(10'h000, 2'b01, 1);
        convert(10'h001, 2'b10, 2);

        // R7 go write mid-conversion
        vin = 10'h1C3; clk_sel = 2'b00; tick_div = 3;
        pulse_go(1'b1);
        do @(negedge clk); while (!(m_phase == 2 && m_ticks == 4));
        pulse_go(1'b1);
        wait_idle();
        @(negedge clk);
        chk("R7 result unaffected", int'(result), 10'h1C3);

        // R8 abort during conversion
        clear_flag();
        vin = 10'h155;
        pulse_go(1'b1);
        do @(negedge clk); while (!(m_phase == 2 && m_ticks == 5));
        pulse_go(1'b0);
        @(negedge clk);
        chk("R8 result kept", int'(result), 10'h1C3);
        chk("R8 flag not set", int'(irq_flag), 0);
        chk("R8 go cleared", int'(go_done), 0);
        chk("R8 sampling back", int'(sample_en), 1);
        repeat (40) @(negedge clk);
        chk("R8 dac idle", int'(dac_code), 0);

        // R8 abort during start delay (RC)
        clk_sel = 2'b11;
        pulse_go(1'b1);
        do @(negedge clk); while (m_phase != 1);
        pulse_go(1'b0);
        repeat (30) @(negedge clk);
        chk("R8 no conversion after delay abort", int'(sample_en), 1);

        // R9 clear coinciding with completion
        clr_at_done = 1'b1;
        convert(10'h0F0, 2'b10, 2);
        clr_at_done = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 flag held", int'(irq_flag), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule